// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block holds the interrupt enable bits of an 8250-style UART. It latches four interrupt conditions, picks the highest-priority one that is both pending and enabled, and reports it through an identification register. It also drives one interrupt line towards the host. The register file next to it decodes host accesses into single-cycle strobes and passes them in. The serial side raises four level conditions: a receive line error, received data available, transmit holding register empty, and a modem input change.

Each condition has a two-state machine. In `PS_IDLE` the condition is not latched. In `PS_PEND` it is latched. The transition `IDLE->PEND` happens on any clock edge where the source's event input is high. The transition `PEND->IDLE` happens on an edge where that source's clear strobe is high and its event input is low. Every other case holds the state. Master reset puts the transmit-empty machine into `PS_PEND` and the other three into `PS_IDLE`. A priority selector with no state turns the set of pending, enabled sources into the identification value. Reading the identification register counts as a clear only for the transmit-empty source, and only when that same read reports it.

Top module: `uart_irq_ident`

## Requirements
- R1: While master reset `mr` is high and after it falls, with no other input active, `ier_rdata` reads 0x00, `iir_rdata` reads 0x01 and `irq` is low.
- R2: A write (`ier_wr` high at a clock edge) stores `ier_wdata[3:0]`, with bit 0 = received data, bit 1 = transmit empty, bit 2 = line error, bit 3 = modem change. `ier_rdata[7:4]` always reads 0.
- R3: A source's pending flag is set at a clock edge where its event input is high. It then stays set until that source's clear rule applies, whether or not the source is enabled.
- R4: A pending line error is cleared by `rd_lsr`. A pending received-data condition is cleared by `rd_rbr`. A pending modem change is cleared by `rd_msr`. Each clear takes effect at the clock edge where the strobe is high.
- R5: A pending transmit-empty condition is cleared by `wr_thr`. It is also cleared by `rd_iir`, but only if `iir_rdata` reports transmit-empty in that same cycle. An `rd_iir` that reports another source leaves it pending.
- R6: Transmit-empty is pending after master reset. Enabling it with no other access raises `irq` and makes `iir_rdata` read 0x02 right after the enabling write.
- R7: Priority from highest to lowest is line error, received data, transmit empty, modem change. `iir_rdata[0]` is 0 when any enabled source is pending and 1 otherwise. `iir_rdata[2:1]` is 11 for line error, 10 for received data, 01 for transmit empty and 00 for modem change (and 00 when none is pending). `iir_rdata[7:3]` is always 0.
- R8: `irq` is high exactly when at least one source is both pending and enabled, which is always the inverse of `iir_rdata[0]`.
- R9: If a clear strobe and the event for the same source are both high in one cycle, the flag is pending after that edge. A condition that stays high therefore never drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mr | input | 1 | Master reset, active high, asynchronous |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 4 | Enable bits to write |
| ev_rx_err | input | 1 | Receive line error condition |
| ev_rx_data | input | 1 | Received data available condition |
| ev_thre | input | 1 | Transmit holding register empty condition |
| ev_modem | input | 1 | Modem input change condition |
| rd_lsr | input | 1 | Host read of line status |
| rd_rbr | input | 1 | Host read of receive buffer |
| rd_iir | input | 1 | Host read of identification register |
| wr_thr | input | 1 | Host write of transmit holding register |
| rd_msr | input | 1 | Host read of modem status |
| ier_rdata | output | 8 | Enable register read value |
| iir_rdata | output | 8 | Identification register read value |
| irq | output | 1 | Interrupt request |

## Verification
A pending machine in the wrong state shows up at the ports only once its source is enabled and no higher-priority source hides it. `iir_rdata` and `irq` are combinational from the flags, so the fault is visible in the same cycle as the enabling write or the clearing access. The bench therefore loads every pattern of pending flags under every enable mask and compares the identification value with one computed in the bench. It then applies each clear rule and checks the outputs in the cycle right after it. Because a misplaced or stale transmit-empty flag can only be seen through identification reads, that clear rule is tried both when the read reports transmit-empty and when it reports another source.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int NSRC  = 4;
    localparam int IER_W = 4;
    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        SRC_RXERR = 2'd0,
        SRC_RXDAT = 2'd1,
        SRC_THRE  = 2'd2,
        SRC_MODEM = 2'd3
    } src_e;

    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_PEND = 1'b1
    } pend_state_e;

    function automatic logic [1:0] id_code(input src_e s);
        logic [1:0] c;
        unique case (s)
            SRC_RXERR: c = 2'b11;
            SRC_RXDAT: c = 2'b10;
            SRC_THRE:  c = 2'b01;
            SRC_MODEM: c = 2'b00;
            default:   c = 2'b00;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/uirq_pend_cell.sv
module uirq_pend_cell
    import uirq_pkg::*;
#(
    parameter bit RST_PEND = 1'b0
) (
    input  logic clk,
    input  logic mr,
    input  logic ev,
    input  logic clr,
    output logic pend
);

    pend_state_e state_q, state_d;

    always_ff @(posedge clk or posedge mr) begin
        if (mr) state_q <= RST_PEND ? PS_PEND : PS_IDLE;
        else    state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: if (ev)         state_d = PS_PEND;
            PS_PEND: if (clr && !ev) state_d = PS_IDLE;
            default: state_d = PS_IDLE;
        endcase
    end

    always_comb begin
        pend = (state_q == PS_PEND);
    end

    AST_EV_WINS:  assert property (@(posedge clk) disable iff (mr) ev |=> pend);            // R9
    AST_CLR_DROP: assert property (@(posedge clk) disable iff (mr) (clr && !ev) |=> !pend);  // R4
    AST_HOLD:     assert property (@(posedge clk) disable iff (mr) (pend && !clr) |=> pend); // R3

endmodule

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg
    import uirq_pkg::*;
(
    input  logic             clk,
    input  logic             mr,
    input  logic             wr,
    input  logic [IER_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [NSRC-1:0]  en_src
);

    logic [IER_W-1:0] ier_q;

    always_ff @(posedge clk or posedge mr) begin
        if (mr)      ier_q <= '0;
        else if (wr) ier_q <= wdata;
    end

    always_comb begin
        rdata             = {{(REG_W-IER_W){1'b0}}, ier_q};
        en_src[SRC_RXDAT] = ier_q[0];
        en_src[SRC_THRE]  = ier_q[1];
        en_src[SRC_RXERR] = ier_q[2];
        en_src[SRC_MODEM] = ier_q[3];
    end

    AST_IER_LOAD: assert property (@(posedge clk) disable iff (mr)
        wr |=> rdata[IER_W-1:0] == $past(wdata)); // R2

endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
(
    input  logic [NSRC-1:0]  act,
    output logic [REG_W-1:0] iir,
    output logic             any,
    output src_e             sel
);

    always_comb begin
        sel = SRC_MODEM;
        any = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (act[i]) begin
                sel = src_e'(2'(i));
                any = 1'b1;
            end
        end
        iir = {{(REG_W-3){1'b0}}, id_code(sel), ~any};
    end

    always_comb begin
        assert (!any || act[sel]); // R7
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uirq_pkg::*;
(
    input  logic       clk,
    input  logic       mr,
    input  logic       ier_wr,
    input  logic [3:0] ier_wdata,
    input  logic       ev_rx_err,
    input  logic       ev_rx_data,
    input  logic       ev_thre,
    input  logic       ev_modem,
    input  logic       rd_lsr,
    input  logic       rd_rbr,
    input  logic       rd_iir,
    input  logic       wr_thr,
    input  logic       rd_msr,
    output logic [7:0] ier_rdata,
    output logic [7:0] iir_rdata,
    output logic       irq
);

    logic [NSRC-1:0] ev, clr, pend, en, act;
    logic            any;
    src_e            sel;

    always_comb begin
        ev[SRC_RXERR]  = ev_rx_err;
        ev[SRC_RXDAT]  = ev_rx_data;
        ev[SRC_THRE]   = ev_thre;
        ev[SRC_MODEM]  = ev_modem;
        clr[SRC_RXERR] = rd_lsr;
        clr[SRC_RXDAT] = rd_rbr;
        clr[SRC_THRE]  = wr_thr || (rd_iir && any && sel == SRC_THRE);
        clr[SRC_MODEM] = rd_msr;
    end

    uirq_enable_reg u_ier (
        .clk    (clk),
        .mr     (mr),
        .wr     (ier_wr),
        .wdata  (ier_wdata),
        .rdata  (ier_rdata),
        .en_src (en)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        uirq_pend_cell #(.RST_PEND(g == int'(SRC_THRE))) u_cell (
            .clk  (clk),
            .mr   (mr),
            .ev   (ev[g]),
            .clr  (clr[g]),
            .pend (pend[g])
        );
    end

    assign act = pend & en;

    uirq_prio u_prio (
        .act (act),
        .iir (iir_rdata),
        .any (any),
        .sel (sel)
    );

    assign irq = |act;

    AST_IRQ_IIR:     assert property (@(posedge clk) disable iff (mr) irq == !iir_rdata[0]); // R8
    AST_RXERR_FIRST: assert property (@(posedge clk) disable iff (mr)
        (pend[SRC_RXERR] && en[SRC_RXERR]) |-> iir_rdata[3:0] == 4'h6); // R7
    AST_THRE_RDCLR:  assert property (@(posedge clk) disable iff (mr)
        (rd_iir && iir_rdata[3:0] == 4'h2 && !ev_thre) |=> !pend[SRC_THRE]); // R5
    AST_THRE_KEEP:   assert property (@(posedge clk) disable iff (mr)
        (rd_iir && iir_rdata[3:0] != 4'h2 && !wr_thr && pend[SRC_THRE]) |=> pend[SRC_THRE]); // R5

endmodule

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;

    logic       clk = 1'b0;
    logic       mr = 1'b1;
    logic       ier_wr = 1'b0;
    logic [3:0] ier_wdata = '0;
    logic       ev_rx_err = 1'b0, ev_rx_data = 1'b0, ev_thre = 1'b0, ev_modem = 1'b0;
    logic       rd_lsr = 1'b0, rd_rbr = 1'b0, rd_iir = 1'b0, wr_thr = 1'b0, rd_msr = 1'b0;
    logic [7:0] ier_rdata, iir_rdata;
    logic       irq;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    uart_irq_ident dut (
        .clk(clk), .mr(mr), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .ev_rx_err(ev_rx_err), .ev_rx_data(ev_rx_data), .ev_thre(ev_thre), .ev_modem(ev_modem),
        .rd_lsr(rd_lsr), .rd_rbr(rd_rbr), .rd_iir(rd_iir), .wr_thr(wr_thr), .rd_msr(rd_msr),
        .ier_rdata(ier_rdata), .iir_rdata(iir_rdata), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
        end
    endtask

    task automatic idle_inputs();
        ier_wr = 0; ev_rx_err = 0; ev_rx_data = 0; ev_thre = 0; ev_modem = 0;
        rd_lsr = 0; rd_rbr = 0; rd_iir = 0; wr_thr = 0; rd_msr = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        mr = 1;
        tick();
        tick();
        mr = 0;
        tick();
    endtask

    task automatic wr_ier(input logic [3:0] v);
        ier_wr = 1; ier_wdata = v;
        tick();
        ier_wr = 0;
    endtask

    // pending order: 0 line error, 1 rx data, 2 tx empty, 3 modem
    function automatic logic [7:0] model_iir(input logic [3:0] p, input logic [3:0] e);
        logic [3:0] m;
        m[0] = p[0] & e[2];
        m[1] = p[1] & e[0];
        m[2] = p[2] & e[1];
        m[3] = p[3] & e[3];
        if (m[0])      return 8'h06;
        else if (m[1]) return 8'h04;
        else if (m[2]) return 8'h02;
        else if (m[3]) return 8'h00;
        else           return 8'h01;
    endfunction

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2;
        chk("R1 ier in reset", ier_rdata, 8'h00);
        chk("R1 iir in reset", iir_rdata, 8'h01);
        do_reset();
        chk("R1 ier after reset", ier_rdata, 8'h00);
        chk("R1 iir after reset", iir_rdata, 8'h01);
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);

        // R6: tx empty pending from reset
        wr_ier(4'h2);
        chk("R6 irq on enable", {7'd0, irq}, 8'h01);
        chk("R6 iir on enable", iir_rdata, 8'h02);

        // R5: identification read reporting tx empty clears it
        rd_iir = 1; tick(); rd_iir = 0;
        chk("R5 iir read clears", iir_rdata, 8'h01);
        chk("R5 irq after read", {7'd0, irq}, 8'h00);

        // R5: write of holding register clears
        ev_thre = 1; tick(); ev_thre = 0;
        chk("R3 tx empty set", iir_rdata, 8'h02);
        wr_thr = 1; tick(); wr_thr = 0;
        chk("R5 write clears", iir_rdata, 8'h01);

        // R5: read reporting another source leaves tx empty pending
        ev_thre = 1; ev_rx_err = 1; tick(); ev_thre = 0; ev_rx_err = 0;
        wr_ier(4'h6);
        chk("R7 line error first", iir_rdata, 8'h06);
        rd_iir = 1; tick(); rd_iir = 0;
        chk("R5 other source read", iir_rdata, 8'h06);
        rd_lsr = 1; tick(); rd_lsr = 0;
        chk("R5 tx empty kept", iir_rdata, 8'h02);
        wr_thr = 1; tick(); wr_thr = 0;

        // R9: event and clear in one cycle
        wr_ier(4'h1);
        ev_rx_data = 1; rd_rbr = 1; tick(); rd_rbr = 0;
        chk("R9 event beats clear", iir_rdata, 8'h04);
        rd_rbr = 1; tick(); rd_rbr = 0;
        chk("R9 level condition holds", iir_rdata, 8'h04);
        ev_rx_data = 0; rd_rbr = 1; tick(); rd_rbr = 0;
        chk("R4 data read clears", iir_rdata, 8'h01);

        // R3: latched while disabled
        wr_ier(4'h0);
        ev_modem = 1; tick(); ev_modem = 0;
        chk("R3 disabled no irq", {7'd0, irq}, 8'h00);
        wr_ier(4'h8);
        chk("R3 latched while disabled", iir_rdata, 8'h00);
        chk("R8 irq with modem", {7'd0, irq}, 8'h01);

        // sweep every pending pattern under every enable mask
        for (int p = 0; p < 16; p++) begin
            for (int e = 0; e < 16; e++) begin
                do_reset();
                wr_thr = 1;
                ev_rx_err = p[0]; ev_rx_data = p[1]; ev_thre = p[2]; ev_modem = p[3];
                tick();
                idle_inputs();
                wr_ier(4'(e));
                chk("R2 ier readback", ier_rdata, {4'h0, 4'(e)});
                chk("R7 iir sweep", iir_rdata, model_iir(4'(p), 4'(e)));
                chk("R8 irq sweep", {7'd0, irq}, {7'd0, ~model_iir(4'(p), 4'(e))[0]});
                if (e == 15) begin
                    rd_lsr = 1; rd_rbr = 1; rd_msr = 1; wr_thr = 1;
                    tick();
                    idle_inputs();
                    chk("R4 all cleared", iir_rdata, 8'h01);
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule